// File: doc/BRIEF.md
# Unsigned Multiplier with 4-to-2 Compressor Reduction

This block multiplies two unsigned N-bit operands in a single combinational pass and returns the full 2N-bit product. Every partial-product bit is formed at once by AND gates. The rows of the resulting array then pass through successive levels of 4-to-2 compressors. Each level halves the number of rows until two remain. A parallel-prefix carry-propagate adder merges those two rows into the product.

Each compressor is made of two chained full adders. The first adder takes three of the four column bits. It produces a lateral carry that goes sideways into the compressor one column higher at the same level. The second adder combines the first adder's sum, the fourth bit and the lateral carry arriving from the column below. The lateral carry-out is a function of the first three inputs only, so no carry chain can form along a row. When the operand width is not a power of two, the row count is padded up with zero rows. Every level spans the full 2N-bit width, and any column with fewer than four live bits is fed zeros.

The block suits a datapath that needs a product within the same clock period and has no pipeline registers around the multiplier.

Top module: `mul42_top`

## Requirements
- R1: For every pair of N-bit unsigned operands, `prod_out` equals the arithmetic product of `a_in` and `b_in`. The product is a 2N-bit unsigned value with bit 0 as its least significant bit.
- R2: In each compressor, the count of ones among the four column inputs and the lateral carry-in equals the sum output, plus twice the vertical carry, plus twice the lateral carry-out.
- R3: A compressor's lateral carry-out is set when at least two of its first three column inputs are one and clear otherwise. It never depends on the lateral carry-in.
- R4: Each reduction level keeps the arithmetic total of its rows. At every level, the sum of all rows modulo 2^(2N) equals the product.
- R5: When either operand is zero, the product is zero.
- R6: With both operands at their maximum of 2^N-1, the product is 2^(2N) - 2^(N+1) + 1, and its most significant bit is one. For N=8 this is 16'hFE01.
- R7: When one operand is a power of two, 2^k, the product equals the other operand shifted left by k places.
- R8: The final adder returns the sum of the two reduced rows modulo 2^(2N), with a carry that may propagate across the full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | Unsigned multiplicand |
| b_in | input | N | Unsigned multiplier |
| prod_out | output | 2N | Unsigned double-width product |

## Verification
The critical coincidence arises when a compressor receives a lateral carry from the column below at the same moment that all four of its own column bits are one. In that case the column count reaches five, and both the vertical carry and the lateral carry-out leave the compressor together. Operand pairs dense in ones, most of all the two all-ones operands, create this situation in the middle columns, and the bench drives those pairs as directed cases. The result is judged at the product against an independently computed shift-and-add value, while the in-block checks confirm the weighted count at every compressor and the row total at every level. An exhaustive sweep of all 8-bit pairs then covers every other mix of lateral and vertical carries.

// File: rtl/mul42_pkg.sv
package mul42_pkg;
  function automatic logic xor3(logic a, logic b, logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/c42_cell.sv
module c42_cell
  import mul42_pkg::*;
(
  input  logic x0,
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout_lat
);
  logic s_first;

  // first full adder: three column bits, lateral carry independent of cin
  assign s_first  = xor3(x0, x1, x2);
  assign cout_lat = maj3(x0, x1, x2);
  // second full adder: partial sum, fourth bit, lateral carry from below
  assign sum      = xor3(s_first, x3, cin);
  assign carry    = maj3(s_first, x3, cin);

  always_comb begin
    a_r2_count_conserved: assert ((3'(x0) + 3'(x1) + 3'(x2) + 3'(x3) + 3'(cin)) ==
                                  (3'(sum) + 3'({carry, 1'b0}) + 3'({cout_lat, 1'b0})))
      else $error("R2 compressor count mismatch");
    a_r3_lat_set: assert (!((x0 & x1) | (x1 & x2) | (x0 & x2)) || cout_lat)
      else $error("R3 lateral carry missing");
    a_r3_lat_clear: assert (((x0 & x1) | (x1 & x2) | (x0 & x2)) || !cout_lat)
      else $error("R3 lateral carry spurious");
  end
endmodule

// File: rtl/c42_stage.sv
module c42_stage #(
  parameter int W = 16
) (
  input  logic [W-1:0] r0,
  input  logic [W-1:0] r1,
  input  logic [W-1:0] r2,
  input  logic [W-1:0] r3,
  output logic [W-1:0] sum_row,
  output logic [W-1:0] carry_row
);
  localparam int XW = W + 2;

  logic [W-1:0] lat_out;
  logic [W-1:0] lat_in;
  logic [W-1:0] vert;

  assign lat_in    = {lat_out[W-2:0], 1'b0};
  assign carry_row = {vert[W-2:0], 1'b0};

  for (genvar i = 0; i < W; i++) begin : g_col
    c42_cell u_cell (
      .x0      (r0[i]),
      .x1      (r1[i]),
      .x2      (r2[i]),
      .x3      (r3[i]),
      .cin     (lat_in[i]),
      .sum     (sum_row[i]),
      .carry   (vert[i]),
      .cout_lat(lat_out[i])
    );
  end

  // exact weighted total including the carries dropped past the top column
  always_comb begin
    a_r4_stage_total: assert ((XW'(r0) + XW'(r1) + XW'(r2) + XW'(r3)) ==
                              (XW'(sum_row) + (XW'(vert) << 1) + (XW'(lat_out[W-1]) << W)))
      else $error("R4 stage total mismatch");
  end
endmodule

// File: rtl/pp_gen.sv
module pp_gen #(
  parameter int N    = 8,
  parameter int ROWS = 8
) (
  input  logic [N-1:0]              mcand,
  input  logic [N-1:0]              mplier,
  output logic [ROWS-1:0][2*N-1:0]  rows
);
  localparam int W = 2 * N;

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    if (j < N) begin : g_live
      assign rows[j] = W'(mcand & {N{mplier[j]}}) << j;
    end else begin : g_pad
      assign rows[j] = '0;
    end
  end
endmodule

// File: rtl/ks_adder.sv
module ks_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  localparam int LG = $clog2(W);

  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] half;

  // log-depth prefix: in-place update from the top bit down keeps lower operands old
  always_comb begin
    half = x ^ y;
    gen  = x & y;
    prop = half;
    for (int k = 0; k < LG; k++) begin
      for (int i = W - 1; i >= 0; i--) begin
        if (i >= (1 << k)) begin
          gen[i]  = gen[i] | (prop[i] & gen[i - (1 << k)]);
          prop[i] = prop[i] & prop[i - (1 << k)];
        end
      end
    end
    s = half ^ {gen[W-2:0], 1'b0};
  end

  always_comb begin
    a_r8_cpa_sum: assert ({gen[W-1], s} == ((W+1)'(x) + (W+1)'(y)))
      else $error("R8 adder sum mismatch");
  end
endmodule

// File: rtl/mul42_top.sv
module mul42_top #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic [2*N-1:0] prod_out
);
  localparam int W      = 2 * N;
  localparam int LEVELS = $clog2(N) - 1;
  localparam int ROWS_P = 2 ** (LEVELS + 1);

  logic [LEVELS:0][ROWS_P-1:0][W-1:0] rows;

  pp_gen #(.N(N), .ROWS(ROWS_P)) u_pp (
    .mcand (a_in),
    .mplier(b_in),
    .rows  (rows[0])
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int IN_R  = ROWS_P >> l;
    localparam int OUT_R = IN_R / 2;
    for (genvar g = 0; g < IN_R / 4; g++) begin : g_grp
      c42_stage #(.W(W)) u_stage (
        .r0       (rows[l][4*g]),
        .r1       (rows[l][4*g+1]),
        .r2       (rows[l][4*g+2]),
        .r3       (rows[l][4*g+3]),
        .sum_row  (rows[l+1][2*g]),
        .carry_row(rows[l+1][2*g+1])
      );
    end
    for (genvar z = OUT_R; z < ROWS_P; z++) begin : g_zero
      assign rows[l+1][z] = '0;
    end
  end

  ks_adder #(.W(W)) u_cpa (
    .x(rows[LEVELS][0]),
    .y(rows[LEVELS][1]),
    .s(prod_out)
  );

  logic [W-1:0] lvl_total;
  logic [W-1:0] ref_prod;

  always_comb begin
    ref_prod = W'(a_in) * W'(b_in);
    a_r1_product: assert (prod_out == ref_prod)
      else $error("R1 product mismatch");
    for (int l = 0; l <= LEVELS; l++) begin
      lvl_total = '0;
      for (int r = 0; r < ROWS_P; r++) lvl_total = lvl_total + rows[l][r];
      a_r4_level_total: assert (lvl_total == ref_prod)
        else $error("R4 level total mismatch");
    end
  end
endmodule

// File: tb/test_mul42_top.sv
module test_mul42_top;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic [N-1:0] a_in = '0;
  logic [N-1:0] b_in = '0;
  logic [W-1:0] prod_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mul42_top #(.N(N)) i_mul42_top (
    .a_in    (a_in),
    .b_in    (b_in),
    .prod_out(prod_out)
  );

  function automatic logic [W-1:0] shift_add(logic [N-1:0] x, logic [N-1:0] y);
    logic [W-1:0] acc = '0;
    for (int k = 0; k < N; k++) if (y[k]) acc = acc + (W'(x) << k);
    return acc;
  endfunction

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y,
                       input logic [W-1:0] exp, input string tag);
    @(posedge clk);
    a_in = x;
    b_in = y;
    @(negedge clk);
    checks++;
    if (prod_out !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", tag, x, y, prod_out, exp);
    end
  endtask

  initial begin
    // R5: zero operands, also the idle state before any work
    apply(8'd0, 8'd0, 16'd0, "R5");
    apply(8'd0, 8'd255, 16'd0, "R5");
    apply(8'd173, 8'd0, 16'd0, "R5");
    // R6, R8, R2, R3: all-ones, full columns with lateral carries, longest carry
    apply(8'hFF, 8'hFF, 16'hFE01, "R6");
    checks++;
    if (prod_out[W-1] !== 1'b1) begin
      errors++;
      $display("FAIL R6 msb actual=%b expected=1", prod_out[W-1]);
    end
    apply(8'hFF, 8'hFE, 16'hFD02, "R8");
    apply(8'hF7, 8'hEF, shift_add(8'hF7, 8'hEF), "R2");
    apply(8'hAA, 8'h55, shift_add(8'hAA, 8'h55), "R3");
    // R7: power-of-two operand shifts the other
    for (int k = 0; k < N; k++) begin
      apply(8'd1 << k, 8'hB7, W'(8'hB7) << k, "R7");
      apply(8'h6D, 8'd1 << k, W'(8'h6D) << k, "R7");
    end
    // R1: random pairs with fixed seed
    void'($urandom(32'd4242));
    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] ra = N'($urandom);
      logic [N-1:0] rb = N'($urandom);
      apply(ra, rb, shift_add(ra, rb), "R1");
    end
    // R1, R4: exhaustive sweep
    for (int x = 0; x < (1 << N); x++) begin
      for (int y = 0; y < (1 << N); y++) begin
        apply(N'(x), N'(y), W'(x * y), "R1");
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule